// File: doc/BRIEF.md
# CPU system control register bank

This block holds the small set of 16-bit system registers that a processor core exposes in a 32-byte window of its I/O space. A bus master addresses a register by byte address; bits 4:1 select one of sixteen word slots and bit 0 marks the odd byte. Each slot carries its own write rule. Error flags clear when ones are written to them. The CPU error word clears on any write. The size word is derived and read-only. Some registers take a byte written to the odd address into their upper half.

Read data and the non-existent-address flag are combinational on the same cycle as the strobe. Writes take effect at the next clock edge. Hardware error events set bits in the CPU error and memory error registers, and an event always beats a software clear in the same cycle. The program-interrupt-request and stack-limit values are only stored here and are driven out to the logic that uses them.

Top module: `sysreg_bank`

## Requirements
- R1: The slot is bus_addr[4:1]. The slot map is: 2 memory error, 3 cache control, 4 maintenance, 5 hit/miss, 8 lower size, 10 system ID, 11 CPU error, 12 microbreak, 13 interrupt request, 14 stack limit. A read of each slot returns the content of that register.
- R2: Slots 0, 1 and 9 read as zero without error. Slots 6, 7 and 15 raise bus_nxm on both reads and writes. Writes to the read-only slots 0, 1, 8, 9 and 10 raise bus_nxm and change nothing.
- R3: A write to the memory error register clears exactly the bits written as one and leaves the others unchanged.
- R4: Any write to the CPU error register clears it, whatever the data.
- R5: A bit of cpu_err_set or mem_err_set that is high in a cycle reads back as one from the next cycle on. This holds even when a clear of that register happens in the same cycle.
- R6: The lower size slot returns MEM_BYTES/64 - 1 and cannot be written.
- R7: Byte data is always on bus_wdata[7:0]. A byte write to an odd address of the interrupt-request, stack-limit or memory-error register places the byte at bits 15:8, with zeros below. A byte write to an even address places it at bits 7:0, with zeros above. The write rule then applies to that word.
- R8: A word write to the cache control register replaces it. A byte write replaces only the addressed lane: bits 7:0 for an even address, bits 15:8 for an odd address.
- R9: The maintenance and hit/miss slots read as zero. Writes to them are accepted without bus_nxm and have no effect.
- R10: The stack limit stores only the bits set in STK_MASK. stklim_q shows the stored value.
- R11: After reset, the system ID reads SYS_ID (default 0x1234). The cache control, hit/miss, CPU error, memory error, microbreak, interrupt-request and stack-limit registers read zero.
- R12: The microbreak register stores the full written word and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_byte | input | 1 | Byte access when high, word access when low |
| bus_addr | input | 5 | Byte address within the window |
| bus_wdata | input | 16 | Write data (byte data on bits 7:0) |
| cpu_err_set | input | ERR_W | Event inputs that set CPU error bits |
| mem_err_set | input | 16 | Event inputs that set memory error bits |
| bus_rdata | output | 16 | Read data |
| bus_nxm | output | 1 | Non-existent-address response |
| pirq_q | output | 16 | Stored interrupt-request word |
| stklim_q | output | 16 | Stored stack limit |

## Verification
The bench builds the block with MEM_BYTES = 131072, so the size slot must read 0x07FF instead of the default 0x0FFF. This proves that the value is derived from the parameter. STK_MASK stays at 0xFF00, which lets byte writes to the even lane of the stack limit vanish entirely while odd-lane writes survive. With SYS_ID left at its default, the identity value after reset is checked against 0x1234. An event pulse driven together with a clearing write exercises the priority rule directly.

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int          MEM_BYTES = 262144,
  parameter logic [15:0] SYS_ID    = 16'h1234,
  parameter logic [15:0] STK_MASK  = 16'hFF00,
  parameter int          ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_byte,
  input  logic [4:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  input  logic [ERR_W-1:0] cpu_err_set,
  input  logic [15:0]      mem_err_set,
  output logic [15:0]      bus_rdata,
  output logic             bus_nxm,
  output logic [15:0]      pirq_q,
  output logic [15:0]      stklim_q
);
  localparam logic [15:0] SIZE_WORD = 16'(MEM_BYTES / 64 - 1);
  localparam logic [15:0] RD_MAP    = 16'h7F3F;
  localparam logic [15:0] WR_MAP    = 16'h783C;

  logic [3:0]       slot;
  logic             odd;
  logic             wr_ok;
  logic [15:0]      lane_data;
  logic [15:0]      memerr_q, ccr_q, mbrk_q;
  logic [ERR_W-1:0] cpuerr_q;

  assign slot  = bus_addr[4:1];
  assign odd   = bus_addr[0];
  assign wr_ok = bus_wr && WR_MAP[slot];

  assign bus_nxm = (bus_rd && !RD_MAP[slot]) || (bus_wr && !WR_MAP[slot]);

  assign lane_data = !bus_byte ? bus_wdata :
                     odd       ? {bus_wdata[7:0], 8'h00} :
                                 {8'h00, bus_wdata[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memerr_q <= '0;
      cpuerr_q <= '0;
      ccr_q    <= '0;
      mbrk_q   <= '0;
      pirq_q   <= '0;
      stklim_q <= '0;
    end else begin
      memerr_q <= (memerr_q & ~((wr_ok && slot == 4'd2) ? lane_data : 16'h0)) | mem_err_set;
      cpuerr_q <= ((wr_ok && slot == 4'd11) ? '0 : cpuerr_q) | cpu_err_set;
      if (wr_ok) begin
        case (slot)
          4'd3: begin
            if (!bus_byte)  ccr_q       <= bus_wdata;
            else if (odd)   ccr_q[15:8] <= bus_wdata[7:0];
            else            ccr_q[7:0]  <= bus_wdata[7:0];
          end
          4'd12:   mbrk_q   <= bus_wdata;
          4'd13:   pirq_q   <= lane_data;
          4'd14:   stklim_q <= lane_data & STK_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (slot)
        4'd2:    bus_rdata = memerr_q;
        4'd3:    bus_rdata = ccr_q;
        4'd8:    bus_rdata = SIZE_WORD;
        4'd10:   bus_rdata = SYS_ID;
        4'd11:   bus_rdata = 16'(cpuerr_q);
        4'd12:   bus_rdata = mbrk_q;
        4'd13:   bus_rdata = pirq_q;
        4'd14:   bus_rdata = stklim_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module sysreg_bank_chk #(
  parameter int MEM_BYTES = 262144,
  parameter int ERR_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             bus_byte,
  input logic [4:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic [ERR_W-1:0] cpu_err_set,
  input logic [15:0]      mem_err_set,
  input logic [15:0]      bus_rdata,
  input logic             bus_nxm,
  input logic [ERR_W-1:0] cpuerr,
  input logic [15:0]      memerr
);
  localparam logic [15:0] EXP_SIZE = 16'((MEM_BYTES >> 6) - 1);

  p_hole_nxm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[4:1] == 4'd15) |-> bus_nxm);

  p_size_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[4:1] == 4'd8) |-> (bus_rdata == EXP_SIZE && !bus_nxm));

  p_any_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:1] == 4'd11 && cpu_err_set == '0) |=> (cpuerr == '0));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_err_set != '0) |=> ((cpuerr & $past(cpu_err_set)) == $past(cpu_err_set)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:1] == 4'd2 && !bus_byte && mem_err_set == '0)
      |=> ((memerr & $past(bus_wdata)) == 16'h0));
endmodule

bind sysreg_bank sysreg_bank_chk #(.MEM_BYTES(MEM_BYTES), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cpu_err_set(cpu_err_set),
  .mem_err_set(mem_err_set), .bus_rdata(bus_rdata), .bus_nxm(bus_nxm),
  .cpuerr(cpuerr_q), .memerr(memerr_q)
);

// File: tb/sysreg_bank_bench.sv
module sysreg_bank_bench;
  localparam int ERR_W = 8;

  typedef struct {
    logic [15:0] d;
    logic        nx;
    bit          cd;
    string       tag;
  } exp_t;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             bus_rd = 0, bus_wr = 0, bus_byte = 0;
  logic [4:0]       bus_addr = '0;
  logic [15:0]      bus_wdata = '0;
  logic [ERR_W-1:0] cpu_err_set = '0;
  logic [15:0]      mem_err_set = '0;
  logic [15:0]      bus_rdata, pirq_q, stklim_q;
  logic             bus_nxm;

  int   n_chk = 0, n_fail = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  sysreg_bank #(.MEM_BYTES(131072), .STK_MASK(16'hFF00), .ERR_W(ERR_W)) u_sysreg_bank (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cpu_err_set(cpu_err_set),
    .mem_err_set(mem_err_set), .bus_rdata(bus_rdata), .bus_nxm(bus_nxm),
    .pirq_q(pirq_q), .stklim_q(stklim_q)
  );

  always @(negedge clk) begin
    #2;
    if ((bus_rd || bus_wr) && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (bus_nxm !== e.nx || (e.cd && bus_rdata !== e.d)) begin
        n_fail++;
        $display("FAIL %s: rdata=%h nxm=%b expected rdata=%h nxm=%b", e.tag, bus_rdata, bus_nxm, e.d, e.nx);
      end
    end
  end

  task automatic rd(input logic [3:0] s, input logic [15:0] d, input logic nx, input string tag);
    exp_t e;
    @(negedge clk);
    bus_rd = 1; bus_wr = 0; bus_byte = 0; bus_addr = {s, 1'b0};
    cpu_err_set = '0; mem_err_set = '0;
    e.d = d; e.nx = nx; e.cd = 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [3:0] s, input logic byt, input logic od, input logic [15:0] d,
                    input logic nx, input string tag,
                    input logic [ERR_W-1:0] ce = '0, input logic [15:0] me = '0);
    exp_t e;
    @(negedge clk);
    bus_rd = 0; bus_wr = 1; bus_byte = byt; bus_addr = {s, od}; bus_wdata = d;
    cpu_err_set = ce; mem_err_set = me;
    e.d = '0; e.nx = nx; e.cd = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic evt(input logic [ERR_W-1:0] ce, input logic [15:0] me);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; cpu_err_set = ce; mem_err_set = me;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; cpu_err_set = '0; mem_err_set = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_rd = 0; bus_wr = 0; cpu_err_set = '0; mem_err_set = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R11 reset state
    rd(4'd2,  16'h0000, 0, "R11 memerr reset");
    rd(4'd3,  16'h0000, 0, "R11 ccr reset");
    rd(4'd10, 16'h1234, 0, "R11 sysid reset");
    rd(4'd11, 16'h0000, 0, "R11 cpuerr reset");
    rd(4'd12, 16'h0000, 0, "R11 mbrk reset");
    rd(4'd13, 16'h0000, 0, "R11 pirq reset");
    rd(4'd14, 16'h0000, 0, "R11 stklim reset");
    // R6 size
    rd(4'd8,  16'h07FF, 0, "R6 size value");
    wr(4'd8, 0, 0, 16'h1111, 1, "R6 size write nxm");
    rd(4'd8,  16'h07FF, 0, "R6 size unchanged");
    // R2 holes and zero slots
    rd(4'd0,  16'h0000, 0, "R2 slot0 zero");
    rd(4'd1,  16'h0000, 0, "R2 slot1 zero");
    rd(4'd9,  16'h0000, 0, "R2 slot9 zero");
    rd(4'd6,  16'h0000, 1, "R2 slot6 nxm");
    rd(4'd7,  16'h0000, 1, "R2 slot7 nxm");
    rd(4'd15, 16'h0000, 1, "R2 slot15 nxm");
    wr(4'd15, 0, 0, 16'hFFFF, 1, "R2 slot15 write nxm");
    wr(4'd10, 0, 0, 16'hFFFF, 1, "R2 sysid write nxm");
    rd(4'd10, 16'h1234, 0, "R2 sysid unchanged");
    // R5 / R4 cpu error
    evt(8'hA5, 16'h0);
    rd(4'd11, 16'h00A5, 0, "R5 event sets cpuerr");
    wr(4'd11, 0, 0, 16'h0000, 0, "R4 write cpuerr");
    rd(4'd11, 16'h0000, 0, "R4 cleared by zero data");
    wr(4'd11, 0, 0, 16'hFFFF, 0, "R5 clear with event", 8'h03, 16'h0);
    rd(4'd11, 16'h0003, 0, "R5 event beats clear");
    // R3 / R7 memory error
    evt('0, 16'hF0F0);
    rd(4'd2, 16'hF0F0, 0, "R5 event sets memerr");
    wr(4'd2, 0, 0, 16'h3030, 0, "R3 w1c word");
    rd(4'd2, 16'hC0C0, 0, "R3 only ones cleared");
    wr(4'd2, 1, 1, 16'h0040, 0, "R7 memerr odd byte");
    rd(4'd2, 16'h80C0, 0, "R7 odd byte shifted high");
    wr(4'd2, 1, 0, 16'h00C0, 0, "R7 memerr even byte");
    rd(4'd2, 16'h8000, 0, "R7 even byte low lane");
    // R8 cache control
    wr(4'd3, 0, 0, 16'h1234, 0, "R8 ccr word");
    rd(4'd3, 16'h1234, 0, "R8 ccr word read");
    wr(4'd3, 1, 0, 16'h00AB, 0, "R8 ccr even byte");
    rd(4'd3, 16'h12AB, 0, "R8 low lane merged");
    wr(4'd3, 1, 1, 16'h00CD, 0, "R8 ccr odd byte");
    rd(4'd3, 16'hCDAB, 0, "R8 high lane merged");
    // R9 maintenance, hit/miss
    wr(4'd4, 0, 0, 16'hFFFF, 0, "R9 maint write accepted");
    rd(4'd4, 16'h0000, 0, "R9 maint reads zero");
    wr(4'd5, 0, 0, 16'hFFFF, 0, "R9 hitmiss write accepted");
    rd(4'd5, 16'h0000, 0, "R9 hitmiss reads zero");
    // R10 / R7 stack limit
    wr(4'd14, 0, 0, 16'h1357, 0, "R10 stklim word");
    rd(4'd14, 16'h1300, 0, "R10 masked");
    wr(4'd14, 1, 1, 16'h00A5, 0, "R7 stklim odd byte");
    rd(4'd14, 16'hA500, 0, "R7 stklim shifted");
    wr(4'd14, 1, 0, 16'h00FF, 0, "R10 stklim even byte");
    rd(4'd14, 16'h0000, 0, "R10 even byte masked away");
    // R7 interrupt request
    wr(4'd13, 1, 1, 16'h0082, 0, "R7 pirq odd byte");
    rd(4'd13, 16'h8200, 0, "R7 pirq shifted");
    wr(4'd13, 0, 0, 16'h4321, 0, "R1 pirq word");
    rd(4'd13, 16'h4321, 0, "R1 pirq slot read");
    // R12 microbreak
    wr(4'd12, 0, 0, 16'hBEEF, 0, "R12 mbrk write");
    rd(4'd12, 16'hBEEF, 0, "R12 mbrk read");
    rd(4'd3,  16'hCDAB, 0, "R1 ccr slot distinct");
    // R11 reset again
    do_reset();
    rd(4'd3,  16'h0000, 0, "R11 ccr after reset");
    rd(4'd12, 16'h0000, 0, "R11 mbrk after reset");
    rd(4'd10, 16'h1234, 0, "R11 sysid after reset");
    idle();
    idle();
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL all: %0d expected items unchecked, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL all: watchdog expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule